// File: doc/BRIEF.md
# Firmware Load Port Controller

This block sits behind a 16-bit register bridge and lets a host fill an embedded processor's memories before releasing it. The host loads a data-memory word address and then writes 16-bit words to that address. It sets an instruction-memory pointer and streams instructions as pairs of 16-bit writes. Each pair is packed into one 32-bit entry, and the pointer then steps forward by one entry. The host also programs a start program counter and flips a run bit.

Memory addresses are in word units. A data-memory word address is half the byte address. The program counter counts 32-bit words from the start of data memory, so byte 0x1000 becomes 0x400. Every output is registered, so each memory write port pulses for one cycle, one cycle after the host write that caused it. Register reads also return their data one cycle after the read strobe.

The register map is fixed:

| Offset | Access | Purpose |
|--------|--------|---------|
| 0x0000 | write | Data-memory word |
| 0x0001 | read/write | Data-memory word address |
| 0x0002 | write | Companion register, accepted and discarded |
| 0x0004 | read/write | Instruction pointer |
| 0x0005 | write | Instruction half-word |
| 0x0006 | read/write | Program counter |
| 0x8010 | read/write | Run control, bit 0 |
| 0x8046 | read | Status word |

Top module: `fwl_load_ctrl`

## Requirements
- R1: After reset the following outputs are all zero: run_o, pc_o, both write enables, both memory addresses and both memory data outputs. The status register at 0x8046 then reads 0x4400.
- R2: A write to 0x0001 loads the low DRAM_AW bits of the write data as the data-memory word address. A read of 0x0001 returns that address, zero-extended.
- R3: A write to 0x0000 while stopped raises dram_we_o for exactly the next cycle. In that cycle dram_addr_o holds the loaded address and dram_data_o holds the written word. The address does not advance.
- R4: A write to 0x0002, whatever its value, raises no write enable and changes no readback value.
- R5: Instructions are written to 0x0005 in pairs. The first write of a pair is held and produces no instruction-memory write. The second write raises imem_we_o for one cycle with imem_data_o = {first word, second word}.
- R6: Each completed pair is written at the current pointer, which then increments by one. The pointer wraps modulo 2^IMEM_AW.
- R7: A write to 0x0004 sets the pointer to the low IMEM_AW bits of the data and discards any half-received pair. A read of 0x0004 returns the pointer.
- R8: A write to 0x0006 loads the program counter (low PC_W bits, in 32-bit word units) onto pc_o. A read of 0x0006 returns it.
- R9: A write to 0x8010 copies data bit 0 to run_o in the next cycle. A read of 0x8010 returns it in bit 0.
- R10: While run_o is high, writes to 0x0000 and 0x0005 raise no write enable and leave the pair phase unchanged.
- R11: Reading 0x8046 returns 0x4400 when no half pair is pending and 0x0400 while the first half of a pair is held.
- R12: Read data appears on reg_rdata_o one cycle after the read strobe. Offsets not in the map read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 16 | Register offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, one cycle after the read strobe |
| dram_we_o | output | 1 | Data-memory write enable |
| dram_addr_o | output | DRAM_AW | Data-memory word address |
| dram_data_o | output | 16 | Data-memory write word |
| imem_we_o | output | 1 | Instruction-memory write enable |
| imem_addr_o | output | IMEM_AW | Instruction-memory entry address |
| imem_data_o | output | 32 | Instruction-memory write data |
| pc_o | output | PC_W | Start program counter |
| run_o | output | 1 | Processor run control |

## Verification
The bench builds the block with DRAM_AW=4, IMEM_AW=3 and PC_W=8. It can therefore sweep every data-memory address and drive the instruction pointer past its wrap point, all within a short run. The narrow PC_W and DRAM_AW also mean that writes with set upper bits show the truncation behaviour directly. Expected packed instruction words and pointer values are computed arithmetically from the loop index.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  localparam logic [15:0] A_DRAM_DATA = 16'h0000;
  localparam logic [15:0] A_DRAM_ADDR = 16'h0001;
  localparam logic [15:0] A_DRAM_AUX  = 16'h0002;
  localparam logic [15:0] A_IMEM_POS  = 16'h0004;
  localparam logic [15:0] A_IMEM_DATA = 16'h0005;
  localparam logic [15:0] A_PC        = 16'h0006;
  localparam logic [15:0] A_RUN       = 16'h8010;
  localparam logic [15:0] A_STATUS    = 16'h8046;

  localparam logic [15:0] ST_ALIVE     = 16'h0400;
  localparam logic [15:0] ST_PAIR_IDLE = 16'h4000;

  typedef struct packed {
    logic dram_addr_we;
    logic dram_data_we;
    logic imem_pos_we;
    logic imem_data_we;
    logic pc_we;
    logic run_we;
  } strobes_t;
endpackage

// File: rtl/fwl_dram_port.sv
module fwl_dram_port #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_we_i,
  input  logic          data_we_i,
  input  logic [15:0]   wdata_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [15:0]   data_o,
  output logic [AW-1:0] cur_addr_o
);
  logic [AW-1:0] cur_q, addr_q;
  logic [15:0]   data_q;
  logic          we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      we_q   <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (addr_we_i) cur_q <= wdata_i[AW-1:0];
      if (data_we_i) begin
        we_q   <= 1'b1;
        addr_q <= cur_q;
        data_q <= wdata_i;
      end
    end
  end

  assign we_o       = we_q;
  assign addr_o     = addr_q;
  assign data_o     = data_q;
  assign cur_addr_o = cur_q;
endmodule

// File: rtl/fwl_imem_packer.sv
module fwl_imem_packer #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pos_we_i,
  input  logic          data_we_i,
  input  logic [15:0]   wdata_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [31:0]   data_o,
  output logic [AW-1:0] ptr_o,
  output logic          pending_o
);
  localparam logic [AW-1:0] STEP = AW'(1);

  logic [AW-1:0] ptr_q, addr_q;
  logic [15:0]   hi_q;
  logic [31:0]   data_q;
  logic          pend_q, we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      addr_q <= '0;
      hi_q   <= '0;
      data_q <= '0;
      pend_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (pos_we_i) begin
        ptr_q  <= wdata_i[AW-1:0];
        pend_q <= 1'b0;
      end else if (data_we_i) begin
        if (!pend_q) begin
          hi_q   <= wdata_i;
          pend_q <= 1'b1;
        end else begin
          we_q   <= 1'b1;
          addr_q <= ptr_q;
          data_q <= {hi_q, wdata_i};
          ptr_q  <= ptr_q + STEP;
          pend_q <= 1'b0;
        end
      end
    end
  end

  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign data_o    = data_q;
  assign ptr_o     = ptr_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/fwl_ctrl_regs.sv
module fwl_ctrl_regs
  import fwl_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int DRAM_AW = 16,
  parameter int IMEM_AW = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pc_we_i,
  input  logic               run_we_i,
  input  logic               re_i,
  input  logic [15:0]        addr_i,
  input  logic [15:0]        wdata_i,
  input  logic [DRAM_AW-1:0] dram_cur_i,
  input  logic [IMEM_AW-1:0] imem_ptr_i,
  input  logic               pending_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               run_o,
  output logic [15:0]        rdata_o
);
  logic [PC_W-1:0] pc_q;
  logic            run_q;
  logic [15:0]     rdata_q, rd_mux;

  always_comb begin
    case (addr_i)
      A_DRAM_ADDR: rd_mux = 16'(dram_cur_i);
      A_IMEM_POS:  rd_mux = 16'(imem_ptr_i);
      A_PC:        rd_mux = 16'(pc_q);
      A_RUN:       rd_mux = {15'd0, run_q};
      A_STATUS:    rd_mux = ST_ALIVE | (pending_i ? 16'h0000 : ST_PAIR_IDLE);
      default:     rd_mux = 16'h0000;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      run_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (pc_we_i)  pc_q  <= wdata_i[PC_W-1:0];
      if (run_we_i) run_q <= wdata_i[0];
      if (re_i)     rdata_q <= rd_mux;
    end
  end

  assign pc_o    = pc_q;
  assign run_o   = run_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/fwl_load_ctrl.sv
module fwl_load_ctrl
  import fwl_pkg::*;
#(
  parameter int DRAM_AW = 16,
  parameter int IMEM_AW = 10,
  parameter int PC_W    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [15:0]        reg_addr_i,
  input  logic [15:0]        reg_wdata_i,
  output logic [15:0]        reg_rdata_o,
  output logic               dram_we_o,
  output logic [DRAM_AW-1:0] dram_addr_o,
  output logic [15:0]        dram_data_o,
  output logic               imem_we_o,
  output logic [IMEM_AW-1:0] imem_addr_o,
  output logic [31:0]        imem_data_o,
  output logic [PC_W-1:0]    pc_o,
  output logic               run_o
);
  strobes_t           stb;
  logic [DRAM_AW-1:0] dram_cur;
  logic [IMEM_AW-1:0] imem_ptr;
  logic               pending;
  logic               running;

  // memory data paths are closed while the core runs
  always_comb begin
    stb.dram_addr_we = reg_we_i && (reg_addr_i == A_DRAM_ADDR);
    stb.dram_data_we = reg_we_i && (reg_addr_i == A_DRAM_DATA) && !running;
    stb.imem_pos_we  = reg_we_i && (reg_addr_i == A_IMEM_POS);
    stb.imem_data_we = reg_we_i && (reg_addr_i == A_IMEM_DATA) && !running;
    stb.pc_we        = reg_we_i && (reg_addr_i == A_PC);
    stb.run_we       = reg_we_i && (reg_addr_i == A_RUN);
  end

  fwl_dram_port #(.AW(DRAM_AW)) i_dram (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_we_i  (stb.dram_addr_we),
    .data_we_i  (stb.dram_data_we),
    .wdata_i    (reg_wdata_i),
    .we_o       (dram_we_o),
    .addr_o     (dram_addr_o),
    .data_o     (dram_data_o),
    .cur_addr_o (dram_cur)
  );

  fwl_imem_packer #(.AW(IMEM_AW)) i_imem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pos_we_i  (stb.imem_pos_we),
    .data_we_i (stb.imem_data_we),
    .wdata_i   (reg_wdata_i),
    .we_o      (imem_we_o),
    .addr_o    (imem_addr_o),
    .data_o    (imem_data_o),
    .ptr_o     (imem_ptr),
    .pending_o (pending)
  );

  fwl_ctrl_regs #(.PC_W(PC_W), .DRAM_AW(DRAM_AW), .IMEM_AW(IMEM_AW)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_we_i    (stb.pc_we),
    .run_we_i   (stb.run_we),
    .re_i       (reg_re_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .dram_cur_i (dram_cur),
    .imem_ptr_i (imem_ptr),
    .pending_i  (pending),
    .pc_o       (pc_o),
    .run_o      (running),
    .rdata_o    (reg_rdata_o)
  );

  assign run_o = running;
endmodule

// File: rtl/fwl_load_ctrl_chk.sv
module fwl_load_ctrl_chk
  import fwl_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [15:0] reg_addr_i,
  input logic [15:0] reg_wdata_i,
  input logic        dram_we_o,
  input logic        imem_we_o,
  input logic        run_o
);
  AST_DRAM_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_we_o |-> $past(reg_we_i && reg_addr_i == A_DRAM_DATA)); // R3

  AST_IMEM_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_we_o |-> $past(reg_we_i && reg_addr_i == A_IMEM_DATA)); // R5

  AST_AUX_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_DRAM_AUX) |=> (!dram_we_o && !imem_we_o)); // R4

  AST_RUN_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_RUN) |=> (run_o == $past(reg_wdata_i[0]))); // R9

  AST_NO_LOAD_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_we_o || imem_we_o) |-> !$past(run_o)); // R10
endmodule

bind fwl_load_ctrl fwl_load_ctrl_chk i_chk (.*);

// File: tb/test_fwl_load_ctrl.sv
`timescale 1ns/1ps
module test_fwl_load_ctrl;
  localparam int DAW = 4;
  localparam int IAW = 3;
  localparam int PW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic dram_we, imem_we, run;
  logic [DAW-1:0] dram_addr;
  logic [15:0] dram_data;
  logic [IAW-1:0] imem_addr;
  logic [31:0] imem_data;
  logic [PW-1:0] pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fwl_load_ctrl #(.DRAM_AW(DAW), .IMEM_AW(IAW), .PC_W(PW)) i_fwl_load_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .dram_we_o(dram_we), .dram_addr_o(dram_addr), .dram_data_o(dram_data),
    .imem_we_o(imem_we), .imem_addr_o(imem_addr), .imem_data_o(imem_data),
    .pc_o(pc), .run_o(run)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 run", run, 0); chk("R1 pc", pc, 0);
    chk("R1 dram_we", dram_we, 0); chk("R1 imem_we", imem_we, 0);
    chk("R1 dram_addr", dram_addr, 0); chk("R1 dram_data", dram_data, 0);
    chk("R1 imem_addr", imem_addr, 0); chk("R1 imem_data", imem_data, 0);
    rd(16'h8046, v); chk("R1 status", v, 16'h4400);

    // R2/R3 sweep every data-memory address
    for (int i = 0; i < 16; i++) begin
      logic [15:0] d;
      d = 16'(i * 16'h1111) ^ 16'h00A5;
      wr(16'h0001, 16'(i) | 16'hFF00);
      rd(16'h0001, v); chk("R2 addr readback", v, 16'(i));
      wr(16'h0000, d);
      chk("R3 we", dram_we, 1); chk("R3 addr", dram_addr, i);
      chk("R3 data", dram_data, d);
      @(negedge clk); chk("R3 one cycle", dram_we, 0);
      rd(16'h0001, v); chk("R3 no advance", v, 16'(i));
    end

    // R4 companion register has no effect
    rd(16'h0001, v2);
    wr(16'h0002, 16'h0000);
    chk("R4 dram_we", dram_we, 0); chk("R4 imem_we", imem_we, 0);
    wr(16'h0002, 16'hFFFF);
    chk("R4 dram_we", dram_we, 0); chk("R4 imem_we", imem_we, 0);
    rd(16'h0001, v); chk("R4 addr kept", v, v2);
    rd(16'h0004, v); chk("R4 ptr kept", v, 0);
    rd(16'h8046, v); chk("R4 status kept", v, 16'h4400);

    // R5/R6/R11 instruction pairs past wrap
    wr(16'h0004, 16'h0000);
    for (int i = 0; i < 10; i++) begin
      logic [15:0] hi, lo;
      hi = 16'(i * 37 + 5);
      lo = 16'(i * 91 + 3) ^ 16'hC000;
      wr(16'h0005, hi);
      chk("R5 first half no write", imem_we, 0);
      rd(16'h8046, v); chk("R11 pending", v, 16'h0400);
      wr(16'h0005, lo);
      chk("R5 we", imem_we, 1); chk("R5 data", imem_data, {hi, lo});
      chk("R6 addr", imem_addr, i % 8);
      rd(16'h8046, v); chk("R11 idle", v, 16'h4400);
    end
    rd(16'h0004, v); chk("R6 wrapped ptr", v, 16'd2);

    // R7 position write drops a half pair
    wr(16'h0005, 16'hAAAA);
    wr(16'h0004, 16'hFFF5);
    rd(16'h8046, v); chk("R7 phase cleared", v, 16'h4400);
    rd(16'h0004, v); chk("R7 ptr", v, 16'd5);
    wr(16'h0005, 16'h1111); chk("R7 first half", imem_we, 0);
    wr(16'h0005, 16'h2222);
    chk("R7 we", imem_we, 1); chk("R7 addr", imem_addr, 5);
    chk("R7 data", imem_data, 32'h1111_2222);

    // R8 program counter, byte 0x1000 -> 0x400, truncated to PC_W
    wr(16'h0006, 16'h0400); chk("R8 pc trunc", pc, 8'h00);
    wr(16'h0006, 16'h01C3); chk("R8 pc", pc, 8'hC3);
    rd(16'h0006, v); chk("R8 readback", v, 16'h00C3);

    // R9/R10 running blocks loads
    wr(16'h8010, 16'h0001); chk("R9 run set", run, 1);
    rd(16'h8010, v); chk("R9 readback", v, 16'h0001);
    wr(16'h0000, 16'h5A5A); chk("R10 dram blocked", dram_we, 0);
    wr(16'h0005, 16'h7777); chk("R10 imem blocked", imem_we, 0);
    rd(16'h8046, v); chk("R10 phase unchanged", v, 16'h4400);
    wr(16'h8010, 16'hFFFE); chk("R9 run clear", run, 0);
    wr(16'h0005, 16'h3333); chk("R10 resume half", imem_we, 0);
    wr(16'h0005, 16'h4444);
    chk("R10 resume we", imem_we, 1); chk("R10 resume addr", imem_addr, 6);
    chk("R10 resume data", imem_data, 32'h3333_4444);

    // R12 unmapped read and latency
    rd(16'h1234, v); chk("R12 unmapped", v, 0);
    @(negedge clk); re = 1'b1; addr = 16'h0006;
    chk("R12 not yet", rdata, 0);
    @(posedge clk); @(negedge clk); re = 1'b0;
    chk("R12 after one cycle", rdata, 16'h00C3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule